// File: doc/BRIEF.md
# Single-Bit Edit and Carry Logic Unit

This unit carries out one single-bit operation on a byte per valid cycle. A bit index picks the target bit. An operation code picks one of these actions:

- **Edits:** set, clear or flip that bit, or write the incoming carry (or its complement) into it.
- **Test:** report whether the bit is zero.
- **Carry operations:** move the bit (or its complement) into the carry, or merge the bit (or its complement) with the carry by AND, OR or XOR.

The byte itself comes from the surrounding datapath, and so do the current zero and carry flags. Fetching and storing the byte is not part of this unit. The unit returns four things:

- the possibly changed byte;
- a write-back enable, raised only when the byte really was edited;
- the next zero flag;
- the next carry flag.

Results are registered, so each input accepted with `in_valid` produces exactly one output marked by `out_valid` one clock later. A datapath can therefore issue one operation every cycle and use `wr_en` to decide whether the byte goes back to its source.

Top module: `bit_manip_unit`

## Requirements
- R1: While `rst_n` is low, and until the first accepted input, `out_valid`, `wr_en`, `out_byte`, `z_out` and `c_out` are all 0.
- R2: An input sampled with `in_valid` high gives `out_valid` high on the next clock edge. With `in_valid` low, `out_valid` and `wr_en` are low after the next edge.
- R3: The target bit is `bit_idx` modulo 8, so only its low three bits matter (index 11 selects bit 3). No bit other than the target ever differs between `in_byte` and `out_byte`.
- R4: Codes 0 (set), 1 (clear) and 2 (flip) force the target bit to 1, force it to 0, or invert it, and raise `wr_en`.
- R5: Code 3 (test) makes `z_out` 1 when the target bit is 0 and 0 when it is 1. The byte is passed through unchanged and `wr_en` stays 0.
- R6: Code 4 copies the target bit into `c_out`. Code 5 copies its complement into `c_out`. Neither writes back.
- R7: Code 6 writes `c_in` into the target bit and code 7 writes the complement of `c_in`. Both raise `wr_en`.
- R8: Codes 8/9 (AND), 10/11 (OR) and 12/13 (XOR) set `c_out` to the target bit combined with `c_in`. The odd code of each pair uses the inverted bit. None of them writes back.
- R9: For every code without an edit (3, 4, 5, 8 to 15), `wr_en` is 0 and `out_byte` equals `in_byte`.
- R10: Codes 14 and 15 are reserved. They leave the byte and both flags unchanged and do not write back.
- R11: A flag that an operation does not produce is passed on unchanged. `z_out` equals `z_in` for every code except 3. `c_out` equals `c_in` for codes 0 to 3, 6, 7, 14 and 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operation is valid this cycle |
| in_byte | input | 8 | Byte to operate on |
| bit_idx | input | 4 | Target bit number, used modulo 8 |
| op_code | input | 4 | Operation code (see requirements) |
| c_in | input | 1 | Current carry flag |
| z_in | input | 1 | Current zero flag |
| out_valid | output | 1 | Result valid |
| out_byte | output | 8 | Resulting byte |
| wr_en | output | 1 | Byte must be written back |
| z_out | output | 1 | Next zero flag |
| c_out | output | 1 | Next carry flag |

## Verification
The checker assumes that each registered output belongs to the input presented on the cycle before. It also assumes that the flag inputs are the live flags of the issuing datapath, so "unchanged" means equal to the sampled `z_in`/`c_in`. The stimulus keeps to these assumptions by holding inputs steady from one falling edge to the next and by only ever raising `in_valid` for whole cycles. It sweeps all sixteen codes against every index from 0 to 15, so the modulo rule is covered. It also uses several byte patterns and both carry values, and it leaves idle gaps to cover the valid timing.

// File: rtl/bit_manip_pkg.sv
package bit_manip_pkg;

  typedef enum logic [3:0] {
    BOP_SET   = 4'd0,
    BOP_CLR   = 4'd1,
    BOP_FLIP  = 4'd2,
    BOP_TEST  = 4'd3,
    BOP_LD    = 4'd4,
    BOP_LDN   = 4'd5,
    BOP_ST    = 4'd6,
    BOP_STN   = 4'd7,
    BOP_AND   = 4'd8,
    BOP_ANDN  = 4'd9,
    BOP_OR    = 4'd10,
    BOP_ORN   = 4'd11,
    BOP_XOR   = 4'd12,
    BOP_XORN  = 4'd13,
    BOP_RSV_A = 4'd14,
    BOP_RSV_B = 4'd15
  } bop_e;

  // Operations that change the byte and so need write-back.
  function automatic logic op_edits(bop_e op);
    return (op == BOP_SET) || (op == BOP_CLR) || (op == BOP_FLIP) ||
           (op == BOP_ST)  || (op == BOP_STN);
  endfunction

  // Operations that produce a new carry.
  function automatic logic op_makes_carry(bop_e op);
    return (op == BOP_LD)  || (op == BOP_LDN)  ||
           (op == BOP_AND) || (op == BOP_ANDN) ||
           (op == BOP_OR)  || (op == BOP_ORN)  ||
           (op == BOP_XOR) || (op == BOP_XORN);
  endfunction

  // New value of the selected bit for an editing operation.
  function automatic logic edit_bit(bop_e op, logic old_b, logic cy);
    logic nb;
    case (op)
      BOP_SET:  nb = 1'b1;
      BOP_CLR:  nb = 1'b0;
      BOP_FLIP: nb = ~old_b;
      BOP_ST:   nb = cy;
      BOP_STN:  nb = ~cy;
      default:  nb = old_b;
    endcase
    return nb;
  endfunction

  // New carry: the odd code of each pair works on the inverted bit.
  function automatic logic carry_calc(bop_e op, logic sel_b, logic cy);
    logic b;
    logic r;
    b = op[0] ? ~sel_b : sel_b;
    case (op)
      BOP_LD,  BOP_LDN:  r = b;
      BOP_AND, BOP_ANDN: r = b & cy;
      BOP_OR,  BOP_ORN:  r = b | cy;
      BOP_XOR, BOP_XORN: r = b ^ cy;
      default:           r = cy;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bit_mask_gen.sv
module bit_mask_gen #(
  parameter int DATA_W   = 8,
  parameter int IDX_IN_W = 4
) (
  input  logic [IDX_IN_W-1:0] idx,
  output logic [DATA_W-1:0]   mask
);
  // DATA_W is a power of two, so the AND below gives idx modulo DATA_W.
  localparam logic [IDX_IN_W-1:0] WRAP = IDX_IN_W'(DATA_W - 1);

  logic [IDX_IN_W-1:0] idx_mod;
  assign idx_mod = idx & WRAP;

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_dec
    assign mask[gi] = (idx_mod == IDX_IN_W'(gi));
  end
endmodule

// File: rtl/bit_edit_unit.sv
module bit_edit_unit
  import bit_manip_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] mask,
  input  bop_e              op,
  input  logic              cy,
  output logic [DATA_W-1:0] dout,
  output logic              sel_bit
);
  assign sel_bit = |(din & mask);

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
    assign dout[gi] = mask[gi] ? edit_bit(op, din[gi], cy) : din[gi];
  end
endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import bit_manip_pkg::*;
(
  input  bop_e op,
  input  logic sel_bit,
  input  logic c_prev,
  input  logic z_prev,
  output logic c_next,
  output logic z_next,
  output logic wb
);
  always_comb begin
    c_next = op_makes_carry(op) ? carry_calc(op, sel_bit, c_prev) : c_prev;
    z_next = (op == BOP_TEST) ? ~sel_bit : z_prev;
    wb     = op_edits(op);
  end
endmodule

// File: rtl/bit_manip_unit.sv
module bit_manip_unit
  import bit_manip_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int IDX_IN_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [DATA_W-1:0]   in_byte,
  input  logic [IDX_IN_W-1:0] bit_idx,
  input  logic [3:0]          op_code,
  input  logic                c_in,
  input  logic                z_in,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_byte,
  output logic                wr_en,
  output logic                z_out,
  output logic                c_out
);
  bop_e              op;
  logic [DATA_W-1:0] edit_mask;
  logic [DATA_W-1:0] edited;
  logic              sel_bit;
  logic              c_nx, z_nx, wb_nx;

  assign op = bop_e'(op_code);

  bit_mask_gen #(.DATA_W(DATA_W), .IDX_IN_W(IDX_IN_W)) u_mask (
    .idx(bit_idx), .mask(edit_mask)
  );

  bit_edit_unit #(.DATA_W(DATA_W)) u_edit (
    .din(in_byte), .mask(edit_mask), .op(op), .cy(c_in),
    .dout(edited), .sel_bit(sel_bit)
  );

  flag_unit u_flag (
    .op(op), .sel_bit(sel_bit), .c_prev(c_in), .z_prev(z_in),
    .c_next(c_nx), .z_next(z_nx), .wb(wb_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      out_byte  <= '0;
      z_out     <= 1'b0;
      c_out     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid & wb_nx;
      if (in_valid) begin
        out_byte <= edited;
        z_out    <= z_nx;
        c_out    <= c_nx;
      end
    end
  end
endmodule

// File: rtl/bit_manip_chk.sv
module bit_manip_chk #(
  parameter int DATA_W   = 8,
  parameter int IDX_IN_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [DATA_W-1:0]   in_byte,
  input logic [IDX_IN_W-1:0] bit_idx,
  input logic [3:0]          op_code,
  input logic                c_in,
  input logic                z_in,
  input logic                out_valid,
  input logic [DATA_W-1:0]   out_byte,
  input logic                wr_en,
  input logic                z_out,
  input logic                c_out
);
  logic [DATA_W-1:0] cur_mask;
  logic [DATA_W-1:0] p_byte, p_mask;
  logic [3:0]        p_op;
  logic              p_c, p_z, p_vld;

  assign cur_mask = {{(DATA_W-1){1'b0}}, 1'b1} << (bit_idx & IDX_IN_W'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_byte <= '0; p_mask <= '0; p_op <= '0;
      p_c <= 1'b0; p_z <= 1'b0; p_vld <= 1'b0;
    end else begin
      p_byte <= in_byte; p_mask <= cur_mask; p_op <= op_code;
      p_c <= c_in; p_z <= z_in; p_vld <= in_valid;
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == p_vld);

  p_no_write_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !wr_en);

  p_only_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((out_byte ^ p_byte) & ~p_mask) == '0));

  p_write_ops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && wr_en) |-> (p_op inside {4'd0, 4'd1, 4'd2, 4'd6, 4'd7}));

  p_test_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && p_op == 4'd3) |-> (z_out == ((p_byte & p_mask) == '0)));

  p_unchanged_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !wr_en) |-> (out_byte == p_byte));

  p_zero_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && p_op != 4'd3) |-> (z_out == p_z));

  p_carry_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (p_op inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd6, 4'd7, 4'd14, 4'd15}))
      |-> (c_out == p_c));
endmodule

bind bit_manip_unit bit_manip_chk #(.DATA_W(DATA_W), .IDX_IN_W(IDX_IN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
  .bit_idx(bit_idx), .op_code(op_code), .c_in(c_in), .z_in(z_in),
  .out_valid(out_valid), .out_byte(out_byte), .wr_en(wr_en),
  .z_out(z_out), .c_out(c_out)
);

// File: tb/bit_manip_unit_tb.sv
module bit_manip_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic [3:0] bit_idx = '0;
  logic [3:0] op_code = '0;
  logic       c_in = 1'b0;
  logic       z_in = 1'b0;
  logic       out_valid, wr_en, z_out, c_out;
  logic [7:0] out_byte;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] b;
    logic       w, z, c;
    logic [3:0] op;
  } exp_t;

  exp_t q[$];

  always #2.5 clk = ~clk;

  bit_manip_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .bit_idx(bit_idx), .op_code(op_code), .c_in(c_in), .z_in(z_in),
    .out_valid(out_valid), .out_byte(out_byte), .wr_en(wr_en),
    .z_out(z_out), .c_out(c_out)
  );

  function automatic string tag_of(logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd2:  return "R4";
      4'd3:              return "R5";
      4'd4, 4'd5:        return "R6";
      4'd6, 4'd7:        return "R7";
      4'd14, 4'd15:      return "R10";
      default:           return "R8";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model written from the requirement list.
  function automatic exp_t model(logic [7:0] b, int idx, logic [3:0] op,
                                 logic c, logic z);
    exp_t e;
    int   k;
    logic t;
    k = idx % 8;
    t = b[k];
    e.b = b; e.w = 1'b0; e.z = z; e.c = c; e.op = op;
    case (op)
      4'd0:  begin e.b[k] = 1'b1;  e.w = 1'b1; end
      4'd1:  begin e.b[k] = 1'b0;  e.w = 1'b1; end
      4'd2:  begin e.b[k] = !t;    e.w = 1'b1; end
      4'd3:  e.z = (t == 1'b0);
      4'd4:  e.c = t;
      4'd5:  e.c = !t;
      4'd6:  begin e.b[k] = c;     e.w = 1'b1; end
      4'd7:  begin e.b[k] = !c;    e.w = 1'b1; end
      4'd8:  e.c = t && c;
      4'd9:  e.c = !t && c;
      4'd10: e.c = t || c;
      4'd11: e.c = !t || c;
      4'd12: e.c = t != c;
      4'd13: e.c = (!t) != c;
      default: ;
    endcase
    return e;
  endfunction

  task automatic drive(logic [7:0] b, int idx, logic [3:0] op, logic c, logic z);
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; bit_idx = 4'(idx); op_code = op;
    c_in = c; z_in = z;
    q.push_back(model(b, idx, op, c, z));
  endtask

  task automatic idle_and_check();
    @(negedge clk);
    in_valid = 1'b0;
    in_byte = 8'h3C;
    op_code = 4'd0;
    @(negedge clk);
    check(out_valid == 1'b0, "R2", "out_valid idle", int'(out_valid), 0);
    check(wr_en == 1'b0, "R2", "wr_en idle", int'(wr_en), 0);
  endtask

  // Monitor: pops one expected item per valid result.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R2", "unexpected out_valid", 1, 0);
        end else begin
          exp_t e;
          string r;
          e = q.pop_front();
          r = tag_of(e.op);
          check(out_byte == e.b, (e.w ? r : "R9"), "out_byte", int'(out_byte), int'(e.b));
          check(wr_en == e.w, (e.w ? r : "R9"), "wr_en", int'(wr_en), int'(e.w));
          check(z_out == e.z, (e.op == 4'd3 ? "R5" : "R11"), "z_out", int'(z_out), int'(e.z));
          check(c_out == e.c, r, "c_out", int'(c_out), int'(e.c));
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
    check(wr_en == 1'b0, "R1", "wr_en", int'(wr_en), 0);
    check(out_byte == 8'h00, "R1", "out_byte", int'(out_byte), 0);
    check(z_out == 1'b0 && c_out == 1'b0, "R1", "flags", int'({z_out, c_out}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after release", int'(out_valid), 0);

    // R3: index 11 must act on bit 3
    drive(8'h00, 11, 4'd0, 1'b0, 1'b0);
    drive(8'hFF, 15, 4'd1, 1'b1, 1'b1);
    idle_and_check();

    // Sweep: every code against every index, several bytes, both carries.
    foreach (q[i]) ;
    for (int p = 0; p < 4; p++) begin
      logic [7:0] pat;
      pat = (p == 0) ? 8'hA5 : (p == 1) ? 8'h00 : (p == 2) ? 8'hFF : 8'h5A;
      for (int cv = 0; cv < 2; cv++) begin
        for (int op = 0; op < 16; op++) begin
          for (int ix = 0; ix < 16; ix++) begin
            drive(pat, ix, 4'(op), cv[0], ix[0] ^ cv[0]);
          end
        end
        idle_and_check();
      end
    end

    // Back-to-back edits on the same byte pattern (R4, R7)
    drive(8'h81, 7, 4'd2, 1'b0, 1'b1);
    drive(8'h81, 0, 4'd7, 1'b1, 1'b0);
    drive(8'h81, 4, 4'd6, 1'b1, 1'b0);
    idle_and_check();
    idle_and_check();
    check(q.size() == 0, "R2", "pending results", q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule